// File: doc/BRIEF.md
# Time-Slotted Tick Master with Acknowledge Supervision

This block is the timing source of a network of nodes that share one clock. Once every `TICK_PERIOD` cycles it sends a broadcast tick message. Each tick names one slave position and carries that position's payload word. Positions are served in a fixed rotation. After each tick, only the named slave may answer, and it must do so within a short window. A silent slave is recorded as a fault, and the master then reacts according to a two-bit recovery policy.

Each slave position has two node identifiers, a primary and a backup. A per-position selection bit decides which identifier goes into the tick. After reset the master runs a start-up phase. In that phase it sends `START_CMDS` start commands to each position in turn, and each command must be acknowledged. Only after the last position has answered does normal rotation begin. If a primary stays silent during start-up, its backup is tried in its place.

The physical link is outside this block. A tick leaves as a one-cycle strobe with its fields, and an acknowledgement arrives as a valid strobe with a sender identifier.

Top module: `tdma_tick_master`

## Requirements
- R1: `tickValid` is high for exactly one cycle every `TICK_PERIOD` cycles, starting in the first cycle after reset is released, while the master is not halted.
- R2: In normal running, successive ticks address positions 0, 1, …, `NUM_SLAVES-1`, 0, … . `tickId` is the position's primary ID when its selection bit (`useBackup`) is 0 and its backup ID when the bit is 1. `tickData` is that position's payload word.
- R3: An acknowledgement counts only if `ackValid` is high in cycle 1 to `ACK_WINDOW` after the tick cycle (the tick cycle is cycle 0) and `ackId` equals the `tickId` just sent. Acknowledgements with another ID, in the tick cycle itself, or after the window are ignored.
- R4: After reset, every tick carries `tickStart=1`. Each position in ascending order receives `START_CMDS` acknowledged start ticks. After that, normal ticks with `tickStart=0` begin at position 0.
- R5: A tick without a counted acknowledgement sets bit `p` of `faultMask`, where `p` is the addressed position. Fault bits clear only on reset.
- R6: During start-up, a missing acknowledgement from a primary sets that position's `useBackup` bit and restarts its start-command count. A missing acknowledgement from a backup halts the master.
- R7: Policy 0 (shutdown), and the reserved code 3: a missing acknowledgement in normal running sets `halted`. No further tick is sent until reset.
- R8: Policy 1 (restart): a missing acknowledgement in normal running clears all `useBackup` bits and re-enters start-up at position 0.
- R9: Policy 2 (backup): a missing acknowledgement from a primary in normal running sets that position's `useBackup` bit, and rotation continues with the next position. A missing acknowledgement from a backup halts the master.
- R10: Reset clears `faultMask`, `useBackup` and `halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Recovery policy: 0 shutdown, 1 restart, 2 backup, 3 shutdown |
| primaryIds | input | NUM_SLAVES*ID_W | Primary node ID per position; position p in bits [p*ID_W +: ID_W] |
| backupIds | input | NUM_SLAVES*ID_W | Backup node ID per position, same packing |
| payloads | input | NUM_SLAVES*DATA_W | Payload word per position, same packing |
| tickValid | output | 1 | One-cycle tick strobe |
| tickId | output | ID_W | Node ID addressed by the tick |
| tickStart | output | 1 | Tick is a start command |
| tickData | output | DATA_W | Payload carried by the tick |
| ackValid | input | 1 | Acknowledgement strobe |
| ackId | input | ID_W | Sender ID of the acknowledgement |
| faultMask | output | NUM_SLAVES | Sticky per-position fault bits |
| useBackup | output | NUM_SLAVES | Per-position backup selection |
| halted | output | 1 | Network stopped until reset |

## Verification
A wrong slot index or selection bit becomes visible at the very next tick, as a wrong `tickId` or `tickData`. A wrong acceptance decision shows up at the following tick as a changed `faultMask` bit, as a changed rotation, or as ticks that stop. A start counter that is off by one changes how many ticks carry `tickStart` before rotation begins, so the error is visible within one start-up phase. A halt that does not hold shows up as a tick appearing within one period.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  typedef enum logic [1:0] {
    POL_SHUTDOWN = 2'd0,
    POL_RESTART  = 2'd1,
    POL_BACKUP   = 2'd2,
    POL_RSVD     = 2'd3
  } policy_e;

  typedef enum logic {
    MODE_START = 1'b0,
    MODE_RUN   = 1'b1
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tickEn;
    logic startCmd;
    logic selBackup;
  } ctrl_t;
endpackage

// File: rtl/tdma_ctrl.sv
module tdma_ctrl
  import tdma_pkg::*;
#(
  parameter int NUM_SLAVES = 4,
  parameter int START_CMDS = 2,
  localparam int SLOT_W = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1,
  localparam int SC_W = $clog2(START_CMDS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            policy,
  input  logic                  periodEnd,
  input  logic                  ackOk,
  output ctrl_t                 ctl,
  output logic [SLOT_W-1:0]     slot,
  output logic [NUM_SLAVES-1:0] faultMask,
  output logic [NUM_SLAVES-1:0] useBackup,
  output logic                  halted
);
  mode_e           mode;
  logic [SC_W-1:0] startCnt;
  logic            lastSlot;
  logic [SLOT_W-1:0] nextSlot;

  assign lastSlot = (slot == SLOT_W'(NUM_SLAVES - 1));
  assign nextSlot = lastSlot ? '0 : slot + SLOT_W'(1);

  assign ctl.tickEn    = !halted;
  assign ctl.startCmd  = (mode == MODE_START);
  assign ctl.selBackup = useBackup[slot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode      <= MODE_START;
      slot      <= '0;
      startCnt  <= '0;
      faultMask <= '0;
      useBackup <= '0;
      halted    <= 1'b0;
    end else if (periodEnd && !halted) begin
      if (ackOk) begin
        if (mode == MODE_START) begin
          if (startCnt == SC_W'(START_CMDS - 1)) begin
            startCnt <= '0;
            slot     <= nextSlot;
            if (lastSlot) mode <= MODE_RUN;
          end else begin
            startCnt <= startCnt + SC_W'(1);
          end
        end else begin
          slot <= nextSlot;
        end
      end else begin
        faultMask[slot] <= 1'b1;
        if (mode == MODE_START) begin
          if (!useBackup[slot]) begin
            useBackup[slot] <= 1'b1;
            startCnt        <= '0;
          end else begin
            halted <= 1'b1;
          end
        end else begin
          case (policy_e'(policy))
            POL_RESTART: begin
              mode      <= MODE_START;
              slot      <= '0;
              startCnt  <= '0;
              useBackup <= '0;
            end
            POL_BACKUP: begin
              if (!useBackup[slot]) begin
                useBackup[slot] <= 1'b1;
                slot            <= nextSlot;
              end else begin
                halted <= 1'b1;
              end
            end
            default: halted <= 1'b1;
          endcase
        end
      end
    end
  end

  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    int'(slot) < NUM_SLAVES);

  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(faultMask) & ~faultMask) == '0);

  p_backup_has_fault_r9: assert property (@(posedge clk) disable iff (!rstN)
    (useBackup & ~faultMask) == '0);

  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);
endmodule

// File: rtl/tdma_datapath.sv
module tdma_datapath
  import tdma_pkg::*;
#(
  parameter int NUM_SLAVES  = 4,
  parameter int ID_W        = 8,
  parameter int DATA_W      = 8,
  parameter int TICK_PERIOD = 125000,
  parameter int ACK_WINDOW  = 100,
  localparam int SLOT_W = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1,
  localparam int CNT_W  = $clog2(TICK_PERIOD)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrl_t                        ctl,
  input  logic [SLOT_W-1:0]            slot,
  input  logic [NUM_SLAVES*ID_W-1:0]   primaryIds,
  input  logic [NUM_SLAVES*ID_W-1:0]   backupIds,
  input  logic [NUM_SLAVES*DATA_W-1:0] payloads,
  input  logic                         ackValid,
  input  logic [ID_W-1:0]              ackId,
  output logic                         tickValid,
  output logic [ID_W-1:0]              tickId,
  output logic                         tickStart,
  output logic [DATA_W-1:0]            tickData,
  output logic                         periodEnd,
  output logic                         ackOk
);
  logic [CNT_W-1:0] cnt;
  logic             inWindow;
  logic [ID_W-1:0]  expId;

  assign expId     = ctl.selBackup ? backupIds[int'(slot)*ID_W +: ID_W]
                                   : primaryIds[int'(slot)*ID_W +: ID_W];
  assign tickId    = expId;
  assign tickData  = payloads[int'(slot)*DATA_W +: DATA_W];
  assign tickValid = ctl.tickEn && (cnt == '0);
  assign tickStart = ctl.startCmd;
  assign periodEnd = (cnt == CNT_W'(TICK_PERIOD - 1));
  assign inWindow  = (cnt != '0) && (cnt <= CNT_W'(ACK_WINDOW));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      ackOk <= 1'b0;
    end else begin
      cnt <= periodEnd ? '0 : cnt + CNT_W'(1);
      if (cnt == '0)
        ackOk <= 1'b0;
      else if (ctl.tickEn && inWindow && ackValid && (ackId == expId))
        ackOk <= 1'b1;
    end
  end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rstN)
    tickValid |=> !tickValid);

  p_ack_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOk) |-> $past(ackValid && ackId == tickId && cnt != '0));
endmodule

// File: rtl/tdma_tick_master.sv
module tdma_tick_master
  import tdma_pkg::*;
#(
  parameter int NUM_SLAVES  = 4,
  parameter int ID_W        = 8,
  parameter int DATA_W      = 8,
  parameter int TICK_PERIOD = 125000,
  parameter int ACK_WINDOW  = 100,
  parameter int START_CMDS  = 2,
  localparam int SLOT_W = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   policy,
  input  logic [NUM_SLAVES*ID_W-1:0]   primaryIds,
  input  logic [NUM_SLAVES*ID_W-1:0]   backupIds,
  input  logic [NUM_SLAVES*DATA_W-1:0] payloads,
  output logic                         tickValid,
  output logic [ID_W-1:0]              tickId,
  output logic                         tickStart,
  output logic [DATA_W-1:0]            tickData,
  input  logic                         ackValid,
  input  logic [ID_W-1:0]              ackId,
  output logic [NUM_SLAVES-1:0]        faultMask,
  output logic [NUM_SLAVES-1:0]        useBackup,
  output logic                         halted
);
  ctrl_t             ctl;
  logic [SLOT_W-1:0] slot;
  logic              periodEnd;
  logic              ackOk;

  tdma_ctrl #(.NUM_SLAVES(NUM_SLAVES), .START_CMDS(START_CMDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .policy(policy), .periodEnd(periodEnd),
    .ackOk(ackOk), .ctl(ctl), .slot(slot), .faultMask(faultMask),
    .useBackup(useBackup), .halted(halted)
  );

  tdma_datapath #(.NUM_SLAVES(NUM_SLAVES), .ID_W(ID_W), .DATA_W(DATA_W),
                  .TICK_PERIOD(TICK_PERIOD), .ACK_WINDOW(ACK_WINDOW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .slot(slot),
    .primaryIds(primaryIds), .backupIds(backupIds), .payloads(payloads),
    .ackValid(ackValid), .ackId(ackId), .tickValid(tickValid),
    .tickId(tickId), .tickStart(tickStart), .tickData(tickData),
    .periodEnd(periodEnd), .ackOk(ackOk)
  );

  p_halt_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !tickValid);
endmodule

// File: tb/tdma_tick_master_test.sv
module tdma_tick_master_test;
  localparam int NS = 3;
  localparam int TP = 10;
  localparam int AW = 4;
  localparam int SC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] policy = 2'd2;
  logic [NS*8-1:0] primaryIds, backupIds, payloads;
  logic tickValid, tickStart, ackValid, halted;
  logic [7:0] tickId, tickData, ackId;
  logic [NS-1:0] faultMask, useBackup;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tickNum = 0;

  int mMode, mSlot, mCnt, mHalted;
  int mUseB[NS];
  int mFault[NS];
  int aliveP[NS];
  int aliveB[NS];
  int seed = 0;

  always #4 clk = ~clk;

  tdma_tick_master #(.NUM_SLAVES(NS), .ID_W(8), .DATA_W(8), .TICK_PERIOD(TP),
                     .ACK_WINDOW(AW), .START_CMDS(SC)) uut (
    .clk(clk), .rstN(rstN), .policy(policy), .primaryIds(primaryIds),
    .backupIds(backupIds), .payloads(payloads), .tickValid(tickValid),
    .tickId(tickId), .tickStart(tickStart), .tickData(tickData),
    .ackValid(ackValid), .ackId(ackId), .faultMask(faultMask),
    .useBackup(useBackup), .halted(halted)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog R1: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (tick %0d)", req, act, exp, tickNum);
    end
  endtask

  task automatic checkStatus(input string req);
    logic [NS-1:0] eF, eB;
    for (int s = 0; s < NS; s++) begin
      eF[s] = mFault[s][0];
      eB[s] = mUseB[s][0];
    end
    check(faultMask == eF, {req, " faultMask"}, 32'(faultMask), 32'(eF));
    check(useBackup == eB, {req, " useBackup"}, 32'(useBackup), 32'(eB));
    check(halted == mHalted[0], {req, " halted"}, 32'(halted), 32'(mHalted));
  endtask

  task automatic doReset(input logic [1:0] pol);
    ackValid = 1'b0;
    ackId = 8'h00;
    rstN = 1'b0;
    policy = pol;
    seed = seed + 5;
    for (int s = 0; s < NS; s++) begin
      primaryIds[s*8 +: 8] = 8'h10 + 8'(s);
      backupIds[s*8 +: 8]  = 8'h20 + 8'(s);
      payloads[s*8 +: 8]   = 8'hA0 + 8'(s) + 8'(seed);
      mUseB[s] = 0; mFault[s] = 0; aliveP[s] = 1; aliveB[s] = 1;
    end
    mMode = 0; mSlot = 0; mCnt = 0; mHalted = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkStatus("R10 reset");
  endtask

  // kind: 0 normal, 1 wrong id, 2 late, 3 in tick cycle, 4 stray then correct
  task automatic runTicks(input int n, input int kind);
    for (int k = 0; k < n; k++) begin
      int expId, acked, d;
      if (mHalted != 0) begin
        for (int c = 0; c < 3 * TP; c++) begin
          check(!tickValid, "R7 no tick while halted", 32'(tickValid), 0);
          @(negedge clk);
        end
        checkStatus("R7 halted");
        return;
      end
      expId = (mUseB[mSlot] != 0) ? 32'h20 + mSlot : 32'h10 + mSlot;
      checkStatus("R5 status");
      check(tickValid, "R1 tick present", 32'(tickValid), 1);
      check(tickId == 8'(expId), "R2 tickId", 32'(tickId), 32'(expId));
      check(tickData == 8'hA0 + 8'(mSlot) + 8'(seed), "R2 tickData",
            32'(tickData), 32'(8'hA0 + 8'(mSlot) + 8'(seed)));
      check(tickStart == (mMode == 0), "R4 tickStart", 32'(tickStart),
            32'(mMode == 0));
      d = 1 + (tickNum % AW);
      if (kind == 3) begin ackValid = 1'b1; ackId = 8'(expId); end
      for (int c = 1; c < TP; c++) begin
        @(negedge clk);
        ackValid = 1'b0;
        check(!tickValid, "R1 single tick per period", 32'(tickValid), 0);
        if (kind == 0 && c == d) begin ackValid = 1'b1; ackId = 8'(expId); end
        if (kind == 1 && c == 2) begin ackValid = 1'b1; ackId = 8'(expId) ^ 8'h40; end
        if (kind == 2 && c == AW + 1) begin ackValid = 1'b1; ackId = 8'(expId); end
        if (kind == 4 && c == 1) begin ackValid = 1'b1; ackId = 8'(expId) ^ 8'h40; end
        if (kind == 4 && c == 3) begin ackValid = 1'b1; ackId = 8'(expId); end
        if (ackValid && ackId == 8'(expId)) begin
          if (mUseB[mSlot] != 0 ? aliveB[mSlot] == 0 : aliveP[mSlot] == 0)
            ackValid = 1'b0;
        end
      end
      @(negedge clk);
      ackValid = 1'b0;
      acked = ((kind == 0 || kind == 4) &&
               ((mUseB[mSlot] != 0) ? aliveB[mSlot] : aliveP[mSlot]) != 0) ? 1 : 0;
      if (acked != 0) begin
        if (mMode == 0) begin
          mCnt++;
          if (mCnt == SC) begin
            mCnt = 0;
            if (mSlot == NS - 1) begin mMode = 1; mSlot = 0; end
            else mSlot++;
          end
        end else mSlot = (mSlot + 1) % NS;
      end else begin
        mFault[mSlot] = 1;
        if (mMode == 0) begin
          if (mUseB[mSlot] == 0) begin mUseB[mSlot] = 1; mCnt = 0; end
          else mHalted = 1;
        end else if (policy == 2'd1) begin
          mMode = 0; mSlot = 0; mCnt = 0;
          for (int s = 0; s < NS; s++) mUseB[s] = 0;
        end else if (policy == 2'd2) begin
          if (mUseB[mSlot] == 0) begin mUseB[mSlot] = 1; mSlot = (mSlot + 1) % NS; end
          else mHalted = 1;
        end else mHalted = 1;
      end
      tickNum++;
    end
  endtask

  initial begin
    ackValid = 1'b0;
    ackId = 8'h00;
    // R9 backup policy, R3 stray acknowledgements
    doReset(2'd2);
    runTicks(6, 0);   // R4 start-up
    runTicks(7, 0);   // R2 rotation
    runTicks(1, 1);   // R3 wrong id -> R9 backup engaged for slot 1
    runTicks(4, 0);
    runTicks(1, 4);   // R3 stray plus correct
    aliveB[1] = 0;
    runTicks(4, 0);   // R9 failing backup halts
    runTicks(1, 0);
    // R8 restart policy with R6 start-up fallback
    doReset(2'd1);
    aliveP[2] = 0;
    runTicks(7, 0);   // R6 slot 2 falls back to backup
    runTicks(3, 0);
    runTicks(1, 2);   // R3 late ack -> R8 restart
    runTicks(10, 0);
    runTicks(1, 3);   // R3 ack in tick cycle -> R8 restart
    runTicks(9, 0);
    // R7 shutdown policy
    doReset(2'd0);
    runTicks(8, 0);
    aliveP[2] = 0;
    runTicks(3, 0);
    runTicks(1, 0);
    // R7 reserved code behaves as shutdown
    doReset(2'd3);
    runTicks(6, 0);
    runTicks(1, 1);
    runTicks(1, 0);
    // R6 primary and backup both silent during start-up
    doReset(2'd2);
    aliveP[1] = 0;
    aliveB[1] = 0;
    runTicks(6, 0);
    runTicks(1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule